// File: doc/BRIEF.md
# Serial Synthesizer Register Load Port

This block is the write side of a three-wire serial control port for a frequency synthesizer. A host drives a serial clock, a data line and a latch-enable line. While latch enable is low, each rising edge of the serial clock shifts one data bit into a 24-bit input word, most significant bit first. When latch enable rises, the word is decoded. Its two lowest bits select one of four holding registers, and the rest of the word is written there.

The word for destination 1 carries an 11-bit field in bits 13 down to 3. Its bit 23 decides where that field goes. When bit 23 is clear, the field is the fractional modulus. When it is set, the field is the resync delay instead. The word for destination 2 carries the 4-bit resync multiplier. Each accepted word produces a one-cycle load event, so that downstream phase-resync logic can notice a newly loaded frequency. A word whose length is not exactly 24 bits is dropped and raises a one-cycle error pulse.

The three serial lines are asynchronous to the system clock. They are synchronized and edge-detected in the system clock domain, so the system clock must run at least twice as fast as the serial clock.

Top module: `srl_load_port`

## Requirements
- R1: After reset, every holding output (fracWord, modulus, resyncDelay, resyncMult, ctrlWord, auxWord) is zero, and loadEvent and frameError are low.
- R2: A word is taken MSB first, one bit per rising serial-clock edge while latch enable is low. It is accepted on the rising edge of latch enable. Bits 1:0 select the destination. Destination 0 stores bits 23:2 in fracWord, and destination 3 stores bits 23:2 in auxWord.
- R3: A destination-1 word with bit 23 = 0 stores bits 13:3 in modulus and leaves resyncDelay unchanged.
- R4: A destination-1 word with bit 23 = 1 stores bits 13:3 in resyncDelay and leaves modulus unchanged.
- R5: A destination-2 word stores bits 15:12 in resyncMult and bits 23:2 in ctrlWord.
- R6: If the number of serial-clock rising edges since latch enable fell is not exactly 24, the word is dropped. No output register changes, frameError is high for exactly one system clock, and loadEvent stays low.
- R7: Each accepted word raises loadEvent for exactly one system clock. loadEvent and frameError are never high together. Holding outputs change only in the cycle where loadEvent is high.
- R8: After a dropped word, the next well-formed 24-bit word is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from host (asynchronous) |
| sdataIn | input | 1 | Serial data from host (asynchronous) |
| latchIn | input | 1 | Latch enable from host (asynchronous) |
| fracWord | output | 22 | Payload of destination 0 |
| modulus | output | 11 | Fractional modulus |
| resyncDelay | output | 11 | Resync delay |
| resyncMult | output | 4 | Resync multiplier |
| ctrlWord | output | 22 | Full payload of destination 2 |
| auxWord | output | 22 | Payload of destination 3 |
| loadEvent | output | 1 | One-cycle pulse per accepted word |
| frameError | output | 1 | One-cycle pulse per dropped word |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 2-bit destination field, an 11-bit modulus field at bit 3, and two synchronizer stages. These defaults make the real field positions reachable, including the load-control bit 23 and the multiplier at bits 15:12. The serial clock runs at one eighth of the system clock, which exercises the oversampling path with some margin. Short (23-bit) and long (25-bit) frames are sent to reach both sides of the exact-length rule.

// File: rtl/srl_pkg.sv
package srl_pkg;
  // Strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic shiftEn;  // take one data bit
    logic commit;   // decode and store the assembled word
    logic reject;   // drop the assembled word
  } ctrlStrobes_t;
endpackage

// File: rtl/srl_sync_edge.sv
module srl_sync_edge #(
  parameter int N_SIG = 3,
  parameter int STAGES = 2,
  parameter logic [N_SIG-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] asyncIn,
  output logic [N_SIG-1:0] level,
  output logic [N_SIG-1:0] rise,
  output logic [N_SIG-1:0] fall
);
  logic [N_SIG-1:0] chain [STAGES];
  logic [N_SIG-1:0] prevLevel;

  genvar st;
  generate
    for (st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[st] <= RESET_VAL;
          else        chain[st] <= chain[st-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLevel <= RESET_VAL;
    else        prevLevel <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prevLevel;
  assign fall  = ~chain[STAGES-1] & prevLevel;
endmodule

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclkRise,
  input  logic         latchLevel,
  input  logic         latchRise,
  input  logic         latchFall,
  output ctrlStrobes_t strobes,
  output logic         frameError
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0] edgeCnt;
  logic             lenOk;

  assign lenOk = (edgeCnt == CNT_FULL);

  always_comb begin
    strobes.shiftEn = sclkRise && !latchLevel && !latchFall;
    strobes.commit  = latchRise && lenOk;
    strobes.reject  = latchRise && !lenOk;
  end

  // Edge counter: cleared when latch falls, saturates above a full word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt <= '0;
    end else if (latchFall) begin
      edgeCnt <= '0;
    end else if (strobes.shiftEn && edgeCnt != CNT_SAT) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameError <= 1'b0;
    else        frameError <= strobes.reject;
  end
endmodule

// File: rtl/srl_datapath.sv
module srl_datapath
  import srl_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int ADDR_W     = 2,
  parameter int MOD_W      = 11,
  parameter int MOD_LSB    = 3,
  parameter int LOADCTL_BIT = 23,
  parameter int MULT_W     = 4,
  parameter int MULT_LSB   = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobes_t              strobes,
  input  logic                      dataBit,
  output logic [WORD_W-ADDR_W-1:0]  fracWord,
  output logic [MOD_W-1:0]          modulus,
  output logic [MOD_W-1:0]          resyncDelay,
  output logic [MULT_W-1:0]         resyncMult,
  output logic [WORD_W-ADDR_W-1:0]  ctrlWord,
  output logic [WORD_W-ADDR_W-1:0]  auxWord,
  output logic                      loadEvent
);
  localparam int PAY_W = WORD_W - ADDR_W;
  localparam logic [ADDR_W-1:0] DEST_FRAC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DEST_MOD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DEST_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] DEST_AUX  = ADDR_W'(3);

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] dest;
  logic [PAY_W-1:0]  payload;
  logic [MOD_W-1:0]  modField;
  logic [MULT_W-1:0] multField;
  logic              loadCtl;

  assign dest      = shiftReg[ADDR_W-1:0];
  assign payload   = shiftReg[WORD_W-1:ADDR_W];
  assign modField  = shiftReg[MOD_LSB +: MOD_W];
  assign multField = shiftReg[MULT_LSB +: MULT_W];
  assign loadCtl   = shiftReg[LOADCTL_BIT];

  // MSB-first input shift register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dataBit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fracWord    <= '0;
      modulus     <= '0;
      resyncDelay <= '0;
      resyncMult  <= '0;
      ctrlWord    <= '0;
      auxWord     <= '0;
    end else if (strobes.commit) begin
      unique case (dest)
        DEST_FRAC: fracWord <= payload;
        DEST_MOD: begin
          if (loadCtl) resyncDelay <= modField;
          else         modulus     <= modField;
        end
        DEST_CTRL: begin
          ctrlWord   <= payload;
          resyncMult <= multField;
        end
        DEST_AUX: auxWord <= payload;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loadEvent <= 1'b0;
    else        loadEvent <= strobes.commit;
  end
endmodule

// File: rtl/srl_load_port.sv
module srl_load_port
  import srl_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int ADDR_W      = 2,
  parameter int MOD_W       = 11,
  parameter int MOD_LSB     = 3,
  parameter int LOADCTL_BIT = 23,
  parameter int MULT_W      = 4,
  parameter int MULT_LSB    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclkIn,
  input  logic                     sdataIn,
  input  logic                     latchIn,
  output logic [WORD_W-ADDR_W-1:0] fracWord,
  output logic [MOD_W-1:0]         modulus,
  output logic [MOD_W-1:0]         resyncDelay,
  output logic [MULT_W-1:0]        resyncMult,
  output logic [WORD_W-ADDR_W-1:0] ctrlWord,
  output logic [WORD_W-ADDR_W-1:0] auxWord,
  output logic                     loadEvent,
  output logic                     frameError
);
  // Bit order on the synchronizer bus: {latch, data, sclk}.
  localparam int IDX_SCLK  = 0;
  localparam int IDX_DATA  = 1;
  localparam int IDX_LATCH = 2;

  logic [2:0]   syncLevel;
  logic [2:0]   syncRise;
  logic [2:0]   syncFall;
  ctrlStrobes_t strobes;

  srl_sync_edge #(
    .N_SIG(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({latchIn, sdataIn, sclkIn}),
    .level(syncLevel), .rise(syncRise), .fall(syncFall)
  );

  srl_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclkRise(syncRise[IDX_SCLK]),
    .latchLevel(syncLevel[IDX_LATCH]),
    .latchRise(syncRise[IDX_LATCH]),
    .latchFall(syncFall[IDX_LATCH]),
    .strobes(strobes),
    .frameError(frameError)
  );

  srl_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .MOD_W(MOD_W), .MOD_LSB(MOD_LSB),
    .LOADCTL_BIT(LOADCTL_BIT), .MULT_W(MULT_W), .MULT_LSB(MULT_LSB)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobes(strobes),
    .dataBit(syncLevel[IDX_DATA]),
    .fracWord(fracWord), .modulus(modulus), .resyncDelay(resyncDelay),
    .resyncMult(resyncMult), .ctrlWord(ctrlWord), .auxWord(auxWord),
    .loadEvent(loadEvent)
  );

  logic unusedFall;
  assign unusedFall = |{syncFall[IDX_SCLK], syncFall[IDX_DATA], syncRise[IDX_DATA]};
endmodule

// File: rtl/srl_load_port_chk.sv
module srl_load_port_chk #(
  parameter int PAY_W  = 22,
  parameter int MOD_W  = 11,
  parameter int MULT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PAY_W-1:0]  fracWord,
  input logic [MOD_W-1:0]  modulus,
  input logic [MOD_W-1:0]  resyncDelay,
  input logic [MULT_W-1:0] resyncMult,
  input logic [PAY_W-1:0]  ctrlWord,
  input logic [PAY_W-1:0]  auxWord,
  input logic              loadEvent,
  input logic              frameError
);
  assert_event_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(loadEvent && frameError));

  assert_event_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loadEvent |=> !loadEvent);

  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameError |=> !frameError);

  assert_hold_unless_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !loadEvent |-> $stable({fracWord, modulus, resyncDelay, resyncMult, ctrlWord, auxWord}));

  assert_mod_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !($changed(modulus) && $changed(resyncDelay)));

  assert_mult_with_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(resyncMult) |-> loadEvent);
endmodule

bind srl_load_port srl_load_port_chk #(
  .PAY_W(WORD_W - ADDR_W), .MOD_W(MOD_W), .MULT_W(MULT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fracWord(fracWord), .modulus(modulus), .resyncDelay(resyncDelay),
  .resyncMult(resyncMult), .ctrlWord(ctrlWord), .auxWord(auxWord),
  .loadEvent(loadEvent), .frameError(frameError)
);

// File: tb/srl_load_port_tb.sv
`timescale 1ns/1ps
module srl_load_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclkIn = 1'b0;
  logic sdataIn = 1'b0;
  logic latchIn = 1'b1;
  logic [21:0] fracWord, ctrlWord, auxWord;
  logic [10:0] modulus, resyncDelay;
  logic [3:0]  resyncMult;
  logic        loadEvent, frameError;

  int checks = 0;
  int errors = 0;
  int loadCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;

  // Bench-side model of the holding registers.
  logic [21:0] expFrac = '0, expCtrl = '0, expAux = '0;
  logic [10:0] expMod = '0, expDelay = '0;
  logic [3:0]  expMult = '0;

  always #2.5 clk = ~clk;

  srl_load_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclkIn), .sdataIn(sdataIn), .latchIn(latchIn),
    .fracWord(fracWord), .modulus(modulus), .resyncDelay(resyncDelay),
    .resyncMult(resyncMult), .ctrlWord(ctrlWord), .auxWord(auxWord),
    .loadEvent(loadEvent), .frameError(frameError)
  );

  always @(negedge clk) begin
    if (rst_n && loadEvent) loadCnt++;
    if (rst_n && frameError) errCnt++;
  end

  // Destination in bits 1:0; see the requirements for field positions.
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'hABCDE0,  // dest 0
    24'h0003E9,  // dest 1, ctl 0, modulus 125
    24'h801F41,  // dest 1, ctl 1, delay 1000
    24'h5AA002,  // dest 2, mult 10
    24'hFFFFFF,  // dest 3
    24'hC07FF9,  // dest 1, ctl 1, delay all ones, junk bits
    24'h7FC001,  // dest 1, ctl 0, modulus 0, junk bits
    24'h00F002   // dest 2, mult 15
  };

  task automatic check(string req, string name, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, name, act, exp);
    end
  endtask

  task automatic modelApply(logic [23:0] w);
    case (w[1:0])
      2'd0: expFrac = w[23:2];
      2'd1: if (w[23]) expDelay = w[13:3]; else expMod = w[13:3];
      2'd2: begin expCtrl = w[23:2]; expMult = w[15:12]; end
      default: expAux = w[23:2];
    endcase
  endtask

  task automatic waitClk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send n bits of data, MSB (bit n-1) first, then raise latch.
  task automatic sendBits(logic [31:0] data, int n);
    latchIn = 1'b0;
    waitClk(6);
    for (int i = n - 1; i >= 0; i--) begin
      sdataIn = data[i];
      sclkIn = 1'b0;
      waitClk(4);
      sclkIn = 1'b1;
      waitClk(4);
    end
    sclkIn = 1'b0;
    waitClk(4);
    latchIn = 1'b1;
    waitClk(10);
  endtask

  task automatic checkAll(string req);
    check(req, "fracWord", fracWord, expFrac);
    check(req, "modulus", modulus, expMod);
    check(req, "resyncDelay", resyncDelay, expDelay);
    check(req, "resyncMult", resyncMult, expMult);
    check(req, "ctrlWord", ctrlWord, expCtrl);
    check(req, "auxWord", auxWord, expAux);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    waitClk(100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    int prevLoad;
    int prevErr;
    waitClk(4);
    // R1: reset state
    checkAll("R1");
    check("R1", "loadEvent", loadEvent, 0);
    check("R1", "frameError", frameError, 0);
    rst_n = 1'b1;
    waitClk(6);

    // R2 R3 R4 R5 R7: table walk
    for (int v = 0; v < NVEC; v++) begin
      prevLoad = loadCnt;
      prevErr = errCnt;
      sendBits({8'h0, VEC[v]}, 24);
      modelApply(VEC[v]);
      case (VEC[v][1:0])
        2'd1: checkAll(VEC[v][23] ? "R4" : "R3");
        2'd2: checkAll("R5");
        default: checkAll("R2");
      endcase
      check("R7", "loadEvent cycles", loadCnt - prevLoad, 1);
      check("R7", "frameError cycles", errCnt - prevErr, 0);
    end

    // R6: short frame (23 bits) is dropped
    prevLoad = loadCnt;
    prevErr = errCnt;
    sendBits(32'h0001F3, 23);
    checkAll("R6");
    check("R6", "short loadEvent", loadCnt - prevLoad, 0);
    check("R6", "short frameError", errCnt - prevErr, 1);

    // R6: long frame (25 bits) is dropped
    prevLoad = loadCnt;
    prevErr = errCnt;
    sendBits(32'h00007FD, 25);
    checkAll("R6");
    check("R6", "long loadEvent", loadCnt - prevLoad, 0);
    check("R6", "long frameError", errCnt - prevErr, 1);

    // R8: recovery after a dropped word
    prevLoad = loadCnt;
    sendBits(32'h00123C, 24);
    modelApply(24'h00123C);
    checkAll("R8");
    check("R8", "recovery loadEvent", loadCnt - prevLoad, 1);

    // R1: reset clears state again
    rst_n = 1'b0;
    waitClk(3);
    expFrac = '0; expMod = '0; expDelay = '0; expMult = '0; expCtrl = '0; expAux = '0;
    checkAll("R1");
    finish();
  end
endmodule